// File: doc/BRIEF.md
# Call Frame Save/Restore Sequencer

This block is the multi-cycle engine that a 16-bit accumulator machine uses to enter and leave a subroutine. On a call it reads an argument count from the top of the stack and works out where the caller's arguments start. It then saves the general and special registers, the old frame pointer and a running frame-size counter to a downward-growing stack in byte-addressed memory. Finally it links a new frame. On a return it rewinds the stack pointer to the frame pointer, pops every saved value back in reverse order, reads the argument count the caller left, and drops that many words.

The stack pointer, frame pointer and frame-size counter live inside the block. The general registers, the parameter pointer, the accumulator and the instruction pointer live in an external register file. The block reaches that file through one combinational read port and one write port. Memory is a single 16-bit word port with a request/ready handshake. The memory stores each word low byte first. A one-cycle request and a one-cycle done pulse frame every operation.

Top module: `call_frame_seq`

## Requirements
- R1: After reset the stack pointer and frame pointer are 0xFFFE, the frame-size counter is 0, and busy and done are low.
- R2: A call first reads the word at SP+2 as the argument count N. The new parameter pointer is 0 when N is 0, and SP+2+2N otherwise, using SP as it was when the call was accepted.
- R3: Each push writes one word at the current SP, then lowers SP by 2 and raises the frame-size counter by 2. Pushes happen in this order: register-file slots 0..9 (R1..R10), slot 10 (PP), slot 11 (ACC), slot 12 (IP), the frame pointer, then the frame-size counter.
- R4: When a call completes, the parameter pointer (slot 10) holds the value from R2, FP equals the final SP, and the frame-size counter is 0.
- R5: A return first loads SP from FP. Each pop raises SP by 2 before it reads the word at the new SP. The first pop reloads the frame-size counter, then FP, then slots 12, 11, 10, 9 .. 0.
- R6: After the register pops, a return pops one more word as a count M and then pops and discards M further words. The final SP is 2(M+1) above the address from which slot 0 was read.
- R7: A memory request keeps its address, direction and write data unchanged until the cycle in which ready is high. Each access completes only in that cycle.
- R8: busy is high from the cycle after a request is accepted through the cycle of a one-cycle done pulse. It is low in the cycle after done, and no memory request is made while idle.
- R9: Requests that arrive while busy have no effect. When call and return are requested together while idle, the call is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_req | input | 1 | Start a frame save (sampled when idle) |
| ret_req | input | 1 | Start a frame restore (sampled when idle) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Word to write |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read word, valid with ready |
| rf_idx | output | 4 | Register-file slot for read or write |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data of slot rf_idx |
| sp_o | output | 16 | Stack pointer |
| fp_o | output | 16 | Frame pointer |
| fsize_o | output | 16 | Frame-size counter |

## Verification
A call finishes after one accept cycle, the count read, fifteen pushes, one link cycle and the done cycle. A return finishes after the pops and discards. Every memory access stretches by the cycles ready stays low, so no result is due at a fixed offset from the request. Every result is therefore taken at the falling edge of the cycle that shows done, when the last register-file and pointer updates have already been clocked in. There the monitor pops the expected frame state that the driver queued from its own model when it issued the request. Busy is sampled at the falling edge one cycle after the request and one cycle after done. Hand-computed words in the stack image and final pointers are read once done has been seen.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARGC,
      ST_PUSH,
      ST_LINK,
      ST_POP,
      ST_DROP,
      ST_DONE
   } cfs_state_e;

   typedef enum logic [2:0] {
      PTR_HOLD,
      PTR_DOWN,
      PTR_UP,
      PTR_REWIND,
      PTR_LINK
   } cfs_ptr_op_e;

endpackage

// File: rtl/cfs_stack_regs.sv
module cfs_stack_regs
   import cfs_pkg::*;
#(
   parameter int W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  cfs_ptr_op_e op,
   input  logic        fp_load,
   input  logic        fs_load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] sp,
   output logic [W-1:0] fp,
   output logic [W-1:0] fs
);
   localparam int          STEP = W / 8;
   localparam logic [W-1:0] TOP = ~W'(STEP - 1);

   logic [W-1:0] sp_q, fp_q, fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= TOP;
         fp_q <= TOP;
         fs_q <= '0;
      end else begin
         case (op)
            PTR_DOWN:   sp_q <= sp_q - W'(STEP);
            PTR_UP:     sp_q <= sp_q + W'(STEP);
            PTR_REWIND: sp_q <= fp_q;
            default:    sp_q <= sp_q;
         endcase

         if (fp_load)
            fp_q <= load_val;
         else if (op == PTR_LINK)
            fp_q <= sp_q;

         if (fs_load)
            fs_q <= load_val;
         else begin
            case (op)
               PTR_DOWN: fs_q <= fs_q + W'(STEP);
               PTR_UP:   fs_q <= fs_q - W'(STEP);
               PTR_LINK: fs_q <= '0;
               default:  fs_q <= fs_q;
            endcase
         end
      end
   end

   assign sp = sp_q;
   assign fp = fp_q;
   assign fs = fs_q;
endmodule

// File: rtl/cfs_arg_ptr.sv
module cfs_arg_ptr #(
   parameter int W = 16
) (
   input  logic [W-1:0] sp,
   input  logic [W-1:0] count,
   output logic [W-1:0] ptr
);
   localparam int STEP = W / 8;

   logic [W-1:0] scaled;

   generate
      if ((STEP & (STEP - 1)) == 0) begin : g_shift
         localparam int SH = $clog2(STEP);
         assign scaled = count << SH;
      end else begin : g_mult
         assign scaled = count * W'(STEP);
      end
   endgenerate

   assign ptr = (count == '0) ? '0 : sp + W'(STEP) + scaled;
endmodule

// File: rtl/cfs_seq_fsm.sv
module cfs_seq_fsm
   import cfs_pkg::*;
#(
   parameter int W      = 16,
   parameter int NSAVE  = 13,
   parameter int PP_IDX = 10,
   parameter int RIDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_req,
   input  logic              ret_req,
   input  logic              mem_ready,
   input  logic [W-1:0]      mem_rdata,
   input  logic [W-1:0]      sp,
   input  logic [W-1:0]      fp,
   input  logic [W-1:0]      fs,
   input  logic [W-1:0]      arg_ptr,
   input  logic [W-1:0]      rf_rdata,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [W-1:0]      mem_addr,
   output logic [W-1:0]      mem_wdata,
   output logic [RIDX_W-1:0] rf_idx,
   output logic              rf_we,
   output logic [W-1:0]      rf_wdata,
   output cfs_ptr_op_e       ptr_op,
   output logic              fp_load,
   output logic              fs_load
);
   localparam int STEP   = W / 8;
   localparam int NPUSH  = NSAVE + 2;
   localparam int NPOP   = NSAVE + 3;
   localparam int SLOT_W = $clog2(NPOP + 1);

   cfs_state_e        state_q, state_d;
   logic [SLOT_W-1:0] slot_q, slot_d;
   logic [W-1:0]      arg_q, arg_d;
   logic [W-1:0]      drop_q, drop_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         arg_q   <= '0;
         drop_q  <= '0;
      end else begin
         state_q <= state_d;
         slot_q  <= slot_d;
         arg_q   <= arg_d;
         drop_q  <= drop_d;
      end
   end

   always_comb begin
      state_d   = state_q;
      slot_d    = slot_q;
      arg_d     = arg_q;
      drop_d    = drop_q;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = sp + W'(STEP);
      mem_wdata = '0;
      rf_idx    = '0;
      rf_we     = 1'b0;
      rf_wdata  = mem_rdata;
      ptr_op    = PTR_HOLD;
      fp_load   = 1'b0;
      fs_load   = 1'b0;
      done      = 1'b0;

      case (state_q)
         ST_IDLE: begin
            slot_d = '0;
            if (call_req)
               state_d = ST_ARGC;
            else if (ret_req) begin
               ptr_op  = PTR_REWIND;
               state_d = ST_POP;
            end
         end
         ST_ARGC: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               arg_d   = arg_ptr;
               state_d = ST_PUSH;
            end
         end
         ST_PUSH: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = sp;
            rf_idx   = RIDX_W'(slot_q);
            if (slot_q < SLOT_W'(NSAVE))
               mem_wdata = rf_rdata;
            else if (slot_q == SLOT_W'(NSAVE))
               mem_wdata = fp;
            else
               mem_wdata = fs;
            if (mem_ready) begin
               ptr_op = PTR_DOWN;
               if (slot_q == SLOT_W'(NPUSH - 1))
                  state_d = ST_LINK;
               else
                  slot_d = slot_q + 1'b1;
            end
         end
         ST_LINK: begin
            rf_we    = 1'b1;
            rf_idx   = RIDX_W'(PP_IDX);
            rf_wdata = arg_q;
            ptr_op   = PTR_LINK;
            state_d  = ST_DONE;
         end
         ST_POP: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               ptr_op = PTR_UP;
               slot_d = slot_q + 1'b1;
               if (slot_q == '0)
                  fs_load = 1'b1;
               else if (slot_q == SLOT_W'(1))
                  fp_load = 1'b1;
               else if (slot_q < SLOT_W'(NSAVE + 2)) begin
                  rf_we  = 1'b1;
                  rf_idx = RIDX_W'(SLOT_W'(NSAVE + 1) - slot_q);
               end else begin
                  drop_d  = mem_rdata;
                  state_d = (mem_rdata == '0) ? ST_DONE : ST_DROP;
               end
            end
         end
         ST_DROP: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               ptr_op = PTR_UP;
               drop_d = drop_q - 1'b1;
               if (drop_q == W'(1))
                  state_d = ST_DONE;
            end
         end
         ST_DONE: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq
   import cfs_pkg::*;
#(
   parameter int W       = 16,
   parameter int NUM_GPR = 10,
   localparam int NSAVE  = NUM_GPR + 3,
   localparam int RIDX_W = $clog2(NSAVE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_req,
   input  logic              ret_req,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [W-1:0]      mem_addr,
   output logic [W-1:0]      mem_wdata,
   input  logic              mem_ready,
   input  logic [W-1:0]      mem_rdata,
   output logic [RIDX_W-1:0] rf_idx,
   output logic              rf_we,
   output logic [W-1:0]      rf_wdata,
   input  logic [W-1:0]      rf_rdata,
   output logic [W-1:0]      sp_o,
   output logic [W-1:0]      fp_o,
   output logic [W-1:0]      fsize_o
);
   generate
      if (W < 16 || (W % 8) != 0) begin : g_bad_width
         $error("call_frame_seq: W must be a multiple of 8 and at least 16");
      end
      if (NUM_GPR < 1) begin : g_bad_gpr
         $error("call_frame_seq: NUM_GPR must be at least 1");
      end
   endgenerate

   cfs_ptr_op_e  ptr_op;
   logic         fp_load, fs_load;
   logic [W-1:0] arg_ptr;

   cfs_stack_regs #(.W(W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (ptr_op),
      .fp_load  (fp_load),
      .fs_load  (fs_load),
      .load_val (mem_rdata),
      .sp       (sp_o),
      .fp       (fp_o),
      .fs       (fsize_o)
   );

   cfs_arg_ptr #(.W(W)) u_arg (
      .sp    (sp_o),
      .count (mem_rdata),
      .ptr   (arg_ptr)
   );

   cfs_seq_fsm #(
      .W      (W),
      .NSAVE  (NSAVE),
      .PP_IDX (NUM_GPR),
      .RIDX_W (RIDX_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .call_req  (call_req),
      .ret_req   (ret_req),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .sp        (sp_o),
      .fp        (fp_o),
      .fs        (fsize_o),
      .arg_ptr   (arg_ptr),
      .rf_rdata  (rf_rdata),
      .busy      (busy),
      .done      (done),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .rf_idx    (rf_idx),
      .rf_we     (rf_we),
      .rf_wdata  (rf_wdata),
      .ptr_op    (ptr_op),
      .fp_load   (fp_load),
      .fs_load   (fs_load)
   );
endmodule

// File: rtl/call_frame_seq_chk.sv
module call_frame_seq_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         call_req,
   input logic         ret_req,
   input logic         busy,
   input logic         done,
   input logic         mem_req,
   input logic         mem_we,
   input logic         mem_ready,
   input logic [W-1:0] mem_addr,
   input logic [W-1:0] mem_wdata,
   input logic [W-1:0] sp_o
);
   localparam int STEP = W / 8;

   assert_push_at_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr == sp_o);

   assert_push_moves_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ready |=> sp_o == $past(sp_o) - W'(STEP));

   assert_read_above_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> mem_addr == sp_o + W'(STEP));

   assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !done);

   assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && (call_req || ret_req) |=> busy);
endmodule

bind call_frame_seq call_frame_seq_chk #(.W(W)) u_chk (.*);

// File: tb/call_frame_seq_tb.sv
module call_frame_seq_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, call_req, ret_req, busy, done;
   logic        mem_req, mem_we, mem_ready, rf_we;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, rf_rdata;
   logic [15:0] sp_o, fp_o, fsize_o;
   logic [3:0]  rf_idx;

   call_frame_seq u_dut (
      .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
      .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_we(rf_we),
      .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .sp_o(sp_o), .fp_o(fp_o),
      .fsize_o(fsize_o)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit fin = 0;

   bit [7:0]    dmem[int];
   bit [7:0]    mmem[int];
   logic [15:0] rf[0:12];
   logic [15:0] mreg[0:12];
   logic [15:0] msp, mfp, mfs;

   typedef struct packed {
      logic [15:0]       sp, fp, fs;
      logic [12:0][15:0] regs;
   } item_t;
   item_t q[$];
   string tq[$];

   assign rf_rdata = rf[rf_idx];

   function automatic bit [7:0] rd_d(input logic [15:0] a);
      return dmem.exists(int'(a)) ? dmem[int'(a)] : 8'h00;
   endfunction
   function automatic logic [15:0] wd(input logic [15:0] a);
      return {rd_d(16'(a + 1)), rd_d(a)};
   endfunction
   function automatic bit [7:0] rd_m(input logic [15:0] a);
      return mmem.exists(int'(a)) ? mmem[int'(a)] : 8'h00;
   endfunction

   // memory port: ready and data driven away from the active edge
   always @(negedge clk) begin
      cyc++;
      mem_ready = mem_req && (cyc % 4 != 3);
      mem_rdata = wd(mem_addr);
   end
   always @(posedge clk) begin
      if (rst_n && mem_req && mem_we && mem_ready) begin
         dmem[int'(mem_addr)]          = mem_wdata[7:0];
         dmem[int'(16'(mem_addr + 1))] = mem_wdata[15:8];
      end
      if (rst_n && rf_we) rf[rf_idx] <= rf_wdata;
   end

   // reference model
   function automatic void mwr(input logic [15:0] a, input logic [15:0] v);
      mmem[int'(a)]          = v[7:0];
      mmem[int'(16'(a + 1))] = v[15:8];
   endfunction
   function automatic logic [15:0] mrd(input logic [15:0] a);
      return {rd_m(16'(a + 1)), rd_m(a)};
   endfunction
   function automatic void mpush(input logic [15:0] v);
      mwr(msp, v);
      msp = msp - 16'd2;
      mfs = mfs + 16'd2;
   endfunction
   function automatic logic [15:0] mpop();
      msp = msp + 16'd2;
      mfs = mfs - 16'd2;
      return mrd(msp);
   endfunction
   function automatic void m_call();
      logic [15:0] cnt, a;
      cnt = mrd(16'(msp + 2));
      a = (cnt == 0) ? 16'h0 : 16'(msp + 16'd2 + 16'(cnt * 2));
      for (int i = 0; i < 13; i++) mpush(mreg[i]);
      mpush(mfp);
      mpush(mfs);
      mreg[10] = a;
      mfp = msp;
      mfs = 16'h0;
   endfunction
   function automatic void m_ret();
      logic [15:0] n;
      msp = mfp;
      mfs = mpop();
      mfp = mpop();
      for (int i = 12; i >= 0; i--) mreg[i] = mpop();
      n = mpop();
      for (int j = 0; j < int'(n); j++) void'(mpop());
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: compare completed frame state at done
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q.size() == 0) chk("R8", "done without request", 16'd1, 16'd0);
         else begin
            item_t it;
            string tg;
            it = q.pop_front();
            tg = tq.pop_front();
            chk(tg, "SP", sp_o, it.sp);
            chk(tg, "FP", fp_o, it.fp);
            chk(tg, "frame size", fsize_o, it.fs);
            for (int i = 0; i < 13; i++)
               chk(tg, $sformatf("slot %0d", i), rf[i], it.regs[i]);
         end
      end
   end

   task automatic set_regs(input logic [15:0] base);
      for (int i = 0; i < 13; i++) begin
         rf[i]   = base + 16'(i);
         mreg[i] = base + 16'(i);
      end
   endtask

   // driver: model the operation, queue the expectation, then issue it
   task automatic op(input bit c, input bit r, input string tag, input bit poke);
      item_t it;
      if (c) m_call(); else m_ret();
      it.sp = msp; it.fp = mfp; it.fs = mfs;
      for (int i = 0; i < 13; i++) it.regs[i] = mreg[i];
      q.push_back(it);
      tq.push_back(tag);
      @(negedge clk);
      call_req = c; ret_req = r;
      @(negedge clk);
      call_req = 0; ret_req = 0;
      chk("R8", "busy after accept", 16'(busy), 16'd1);
      if (poke) begin   // R9: requests while busy are ignored
         call_req = 1; ret_req = 1;
         @(negedge clk);
         call_req = 0; ret_req = 0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      chk("R8", "busy after done", 16'(busy), 16'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      msp = 16'hFFFE; mfp = 16'hFFFE; mfs = 16'h0;
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int bad;
      rst_n = 0; call_req = 0; ret_req = 0;
      mem_ready = 0; mem_rdata = '0;
      set_regs(16'h0);
      do_reset();
      // R1: reset state
      chk("R1", "SP", sp_o, 16'hFFFE);
      chk("R1", "FP", fp_o, 16'hFFFE);
      chk("R1", "frame size", fsize_o, 16'h0);
      chk("R1", "busy", 16'(busy), 16'd0);
      chk("R1", "done", 16'(done), 16'd0);

      // scenario A: zero argument count at 0x0000
      set_regs(16'h1100);
      op(1, 0, "R4", 0);
      chk("R4", "SP after call", sp_o, 16'hFFE0);
      chk("R4", "FP after call", fp_o, 16'hFFE0);
      chk("R2", "PP zero count", rf[10], 16'h0000);
      chk("R3", "R1 word", wd(16'hFFFE), 16'h1100);
      chk("R3", "IP word", wd(16'hFFE6), 16'h110C);
      chk("R3", "FP word", wd(16'hFFE4), 16'hFFFE);
      chk("R3", "frame size word", wd(16'hFFE2), 16'h001C);
      set_regs(16'h2200);
      op(1, 0, "R9", 1);
      op(0, 1, "R5", 0);
      op(0, 1, "R5", 0);
      chk("R5", "R1 restored", rf[0], 16'h1100);
      chk("R6", "SP no discards", sp_o, 16'h0000);
      op(1, 1, "R9", 0);
      op(0, 1, "R6", 0);

      // scenario B: argument count 3 at 0x0000, nested pair
      do_reset();
      dmem[0] = 8'h03; dmem[1] = 8'h00;
      mmem[0] = 8'h03; mmem[1] = 8'h00;
      set_regs(16'h3300);
      op(1, 0, "R4", 0);
      chk("R2", "PP count 3", rf[10], 16'h0006);
      set_regs(16'h4400);
      op(1, 0, "R4", 1);
      chk("R2", "PP nested count 28", rf[10], 16'h001A);
      op(0, 1, "R6", 0);
      op(0, 1, "R6", 0);
      chk("R6", "SP after discards", sp_o, 16'h0006);
      chk("R5", "R4 restored", rf[3], 16'h3303);

      // R3: whole stack image against the model
      bad = 0;
      foreach (mmem[k]) if (rd_d(16'(k)) != mmem[k]) bad++;
      chk("R3", "memory image mismatches", 16'(bad), 16'd0);
      chk("R3", "memory footprint", 16'(dmem.num()), 16'(mmem.num()));

      fin = 1;
      summary();
      $finish;
   end
endmodule